// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is a byte-wide asynchronous serial transmitter and receiver reached through a small register bus. Software pushes characters into a transmit queue and pops received characters from a receive queue. Each received character keeps its own error flags. A 12-bit divisor sets the oversampling rate. Each serial bit lasts 16 oversample ticks.

The line format is set through one control byte: word length 5 to 8 bits, optional parity (odd or even), and one or two stop bits. The same byte holds a forced-break bit and the queue-enable bit. Software stops the port through the enable register, rewrites the divisor and the format, and then starts the port again. Two level interrupt outputs report that received data is waiting and that the transmit queue has room.

Register offsets: 0 data (a write queues a character, a read pops one), 1 receive status, 2 divisor bits 7:0, 3 divisor bits 11:8 in bits 3:0, 4 line control, 5 enable (bit 0), 6 flags.

Top module: `mmio_serial`

## Requirements
- R1: After reset the txd output is high, the flags register reads 0x10, irq_rx is low and irq_tx is high.
- R2: Every serial bit lasts exactly 16*(divisor+1) clock cycles. The divisor's bits 7:0 come from offset 2 and its bits 11:8 come from bits 3:0 of offset 3.
- R3: A frame is sent as one low start bit, then the data bits LSB first, then an optional parity bit, then one stop bit (two if line-control bit 3 is set). Line-control bits 6:5 select the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Received data is the sent character masked to that length.
- R4: Line-control bit 1 enables parity and bit 2 selects even parity (clear selects odd). A received parity bit that does not match sets receive-status bit 1.
- R5: A received first stop bit sampled low sets receive-status bit 0 (framing error).
- R6: The receive status register (offset 1) shows the error bits of the character most recently popped from offset 0. A clean character reads 0.
- R7: With line-control bit 4 set, each queue holds 16 characters and keeps their order. Flags bit 5 is set when the transmit queue is full, and a write to a full queue is dropped.
- R8: A character that arrives while the receive queue is full is dropped. Status bit 2 (overrun) is then set on the newest stored entry.
- R9: With line-control bit 4 clear, each queue holds a single character.
- R10: While line-control bit 0 is set, txd is held low.
- R11: While enable bit 0 is clear, nothing is transmitted and txd stays high, but the transmit queue still accepts writes. Clearing the enable bit aborts a frame in progress.
- R12: Flags bit 3 is set while a frame is being transmitted. Flags bit 4 is set while the receive queue is empty.
- R13: irq_rx is high while the receive queue holds data. irq_tx is high while the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (a read of offset 0 pops) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive data waiting |
| irq_tx | output | 1 | Transmit queue has room |

## Verification
The assertions assume that software changes the queue-enable bit only while both queues are empty. They also assume that software changes the divisor and the format only with the port stopped. The stimulus follows both rules: every reconfiguration clears the enable bit first, and the queue mode is switched only after all queued characters have been drained. Received frames come either from a loopback of txd or from bench-timed frames at the same bit period. This keeps the mid-bit sampling inside the window the receiver expects.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int DATA_W  = 8;
    localparam int DIV_W   = 12;
    localparam int ADDR_W  = 3;
    localparam int OSR     = 16;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA   = 3'd0,
        ADDR_STAT   = 3'd1,
        ADDR_DIVLO  = 3'd2,
        ADDR_DIVMID = 3'd3,
        ADDR_LINE   = 3'd4,
        ADDR_CTRL   = 3'd5,
        ADDR_FLAG   = 3'd6
    } reg_addr_e;

    // line control byte, bit 0 at the bottom
    typedef struct packed {
        logic       spare;
        logic [1:0] wlen;
        logic       fifo_en;
        logic       two_stop;
        logic       par_even;
        logic       par_en;
        logic       brk_on;
    } line_cfg_t;

    typedef struct packed {
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } frame_st_e;

    function automatic logic [3:0] word_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic [DATA_W-1:0] mask_word(input logic [DATA_W-1:0] d,
                                                    input logic [1:0] wlen);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < int'(word_bits(wlen)));
        end
        return d & m;
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic [1:0] wlen,
                                       input logic even);
        logic x;
        x = ^mask_word(d, wlen);
        return even ? x : ~x;
    endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         single,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    input  logic                         tag_en,
    input  logic [W-1:0]                 tag_val
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, last;
    logic [CW-1:0] cnt, cap;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign full    = (cnt >= cap);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign last    = (wp == '0) ? AW'(DEPTH-1) : wp - 1'b1;
    assign dout    = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
        if (tag_en && !empty && !do_push) mem[last] <= mem[last] | tag_val;
    end

endmodule

// File: rtl/sport_baud.sv
module sport_baud #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] divisor,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (!en)       cnt <= divisor;
        else if (cnt == '0) cnt <= divisor;
        else                cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int OSR_N = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              two_stop,
    input  logic              brk_on,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int TW = $clog2(OSR_N);

    frame_st_e         st;
    logic [TW-1:0]     tcnt;
    logic [3:0]        bitn;
    logic [DATA_W-1:0] shreg;
    logic              par_q, stop_more, line;
    logic              bit_end;

    assign bit_end = tick && (tcnt == TW'(OSR_N-1));
    assign pop     = en && tick && (st == ST_IDLE) && !fifo_empty;
    assign busy    = (st != ST_IDLE);
    assign txd     = brk_on ? 1'b0 : line;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st        <= ST_IDLE;
            tcnt      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            stop_more <= 1'b0;
            line      <= 1'b1;
        end else begin
            if (st != ST_IDLE && tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
            case (st)
                ST_IDLE: if (pop) begin
                    st    <= ST_START;
                    tcnt  <= '0;
                    shreg <= mask_word(fifo_data, wlen);
                    par_q <= parity_of(fifo_data, wlen, par_even);
                    line  <= 1'b0;
                end
                ST_START: if (bit_end) begin
                    st    <= ST_DATA;
                    line  <= shreg[0];
                    shreg <= shreg >> 1;
                    bitn  <= 4'd1;
                end
                ST_DATA: if (bit_end) begin
                    if (bitn == word_bits(wlen)) begin
                        if (par_en) begin
                            st   <= ST_PAR;
                            line <= par_q;
                        end else begin
                            st        <= ST_STOP;
                            line      <= 1'b1;
                            stop_more <= two_stop;
                        end
                    end else begin
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                        bitn  <= bitn + 1'b1;
                    end
                end
                ST_PAR: if (bit_end) begin
                    st        <= ST_STOP;
                    line      <= 1'b1;
                    stop_more <= two_stop;
                end
                ST_STOP: if (bit_end) begin
                    if (stop_more) stop_more <= 1'b0;
                    else           st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int OSR_N = OSR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    output logic       push,
    output rx_entry_t  entry
);
    localparam int TW   = $clog2(OSR_N);
    localparam int HALF = OSR_N/2 - 1;

    frame_st_e         st;
    logic [TW-1:0]     tcnt;
    logic [3:0]        bitn;
    logic [DATA_W-1:0] shreg;
    logic              perr_q;
    logic              rs1, rs2, rs3;
    logic              samp;

    assign samp = tick && (tcnt == TW'(OSR_N-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rs1 <= 1'b1;
            rs2 <= 1'b1;
            rs3 <= 1'b1;
        end else begin
            rs1 <= rxd;
            rs2 <= rs1;
            rs3 <= rs2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st     <= ST_IDLE;
            tcnt   <= '0;
            bitn   <= '0;
            shreg  <= '0;
            perr_q <= 1'b0;
            push   <= 1'b0;
            entry  <= '0;
        end else begin
            push <= 1'b0;
            if (st != ST_IDLE && tick) tcnt <= samp ? '0 : tcnt + 1'b1;
            case (st)
                ST_IDLE: if (rs3 && !rs2) begin
                    st   <= ST_START;
                    tcnt <= '0;
                end
                ST_START: if (tick && tcnt == TW'(HALF)) begin
                    if (!rs2) begin
                        st     <= ST_DATA;
                        tcnt   <= '0;
                        bitn   <= '0;
                        shreg  <= '0;
                        perr_q <= 1'b0;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_DATA: if (samp) begin
                    shreg[bitn[2:0]] <= rs2;
                    if (bitn == word_bits(wlen) - 4'd1) st <= par_en ? ST_PAR : ST_STOP;
                    else                                bitn <= bitn + 1'b1;
                end
                ST_PAR: if (samp) begin
                    perr_q <= (rs2 != parity_of(shreg, wlen, par_even));
                    st     <= ST_STOP;
                end
                ST_STOP: if (samp) begin
                    push       <= 1'b1;
                    entry.ovr  <= 1'b0;
                    entry.perr <= perr_q;
                    entry.ferr <= !rs2;
                    entry.data <= shreg;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mmio_serial.sv
module mmio_serial
    import sport_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OSR_N      = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_rx,
    output logic              irq_tx
);
    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam int EW = $bits(rx_entry_t);

    logic [DIV_W-1:0]  div_q;
    line_cfg_t         line_q;
    logic              en_q;
    logic [2:0]        stat_q;

    logic              wr_acc, rd_acc;
    logic              tx_push, tx_pop, tx_empty, tx_full, tx_busy;
    logic [DATA_W-1:0] tx_head;
    logic [CW-1:0]     tx_cnt;
    logic              rx_pop, rx_empty, rx_full, rx_push;
    logic [EW-1:0]     rx_dout;
    rx_entry_t         rx_head, rx_new, tag_word;
    logic [CW-1:0]     rx_cnt;
    logic              tick;

    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && bus_rd;
    assign tx_push = wr_acc && (bus_addr == ADDR_DATA);
    assign rx_pop  = rd_acc && (bus_addr == ADDR_DATA);
    assign rx_head = rx_entry_t'(rx_dout);

    always_comb begin
        tag_word     = '0;
        tag_word.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            line_q <= '0;
            en_q   <= 1'b0;
            stat_q <= '0;
        end else begin
            if (wr_acc) begin
                case (bus_addr)
                    ADDR_DIVLO:  div_q[7:0]       <= bus_wdata;
                    ADDR_DIVMID: div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
                    ADDR_LINE:   line_q           <= line_cfg_t'(bus_wdata);
                    ADDR_CTRL:   en_q             <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (rx_pop && !rx_empty) stat_q <= {rx_head.ovr, rx_head.perr, rx_head.ferr};
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA:   bus_rdata = rx_empty ? '0 : rx_head.data;
            ADDR_STAT:   bus_rdata = {5'b0, stat_q};
            ADDR_DIVLO:  bus_rdata = div_q[7:0];
            ADDR_DIVMID: bus_rdata = {{(16-DIV_W){1'b0}}, div_q[DIV_W-1:8]};
            ADDR_LINE:   bus_rdata = line_q;
            ADDR_CTRL:   bus_rdata = {7'b0, en_q};
            ADDR_FLAG:   bus_rdata = {2'b0, tx_full, rx_empty, tx_busy, 3'b0};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_rx = !rx_empty;
    assign irq_tx = !tx_full;

    sport_baud #(.DW(DIV_W)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .divisor (div_q),
        .tick    (tick)
    );

    sport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk     (clk),
        .rst     (rst),
        .single  (!line_q.fifo_en),
        .push    (tx_push),
        .din     (bus_wdata),
        .pop     (tx_pop),
        .dout    (tx_head),
        .empty   (tx_empty),
        .full    (tx_full),
        .count   (tx_cnt),
        .tag_en  (1'b0),
        .tag_val ('0)
    );

    sport_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk     (clk),
        .rst     (rst),
        .single  (!line_q.fifo_en),
        .push    (rx_push),
        .din     (rx_new),
        .pop     (rx_pop),
        .dout    (rx_dout),
        .empty   (rx_empty),
        .full    (rx_full),
        .count   (rx_cnt),
        .tag_en  (rx_push && rx_full),
        .tag_val (tag_word)
    );

    sport_tx #(.OSR_N(OSR_N)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en_q),
        .tick       (tick),
        .wlen       (line_q.wlen),
        .par_en     (line_q.par_en),
        .par_even   (line_q.par_even),
        .two_stop   (line_q.two_stop),
        .brk_on     (line_q.brk_on),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_head),
        .pop        (tx_pop),
        .txd        (txd),
        .busy       (tx_busy)
    );

    sport_rx #(.OSR_N(OSR_N)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .tick     (tick),
        .rxd      (rxd),
        .wlen     (line_q.wlen),
        .par_en   (line_q.par_en),
        .par_even (line_q.par_even),
        .push     (rx_push),
        .entry    (rx_new)
    );

endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          brk,
    input logic          fifo_en,
    input logic          tx_busy,
    input logic          txd,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tx_busy);

    // R12
    busy_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> ($past(tx_cnt) != '0));

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !brk) |-> txd);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

    // R9
    single_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1)));
endmodule

bind mmio_serial sport_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .brk     (line_q.brk_on),
    .fifo_en (line_q.fifo_en),
    .tx_busy (tx_busy),
    .txd     (txd),
    .tx_cnt  (tx_cnt),
    .rx_cnt  (rx_cnt)
);

// File: tb/mmio_serial_tb_top.sv
module mmio_serial_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd, txd, irq_rx, irq_tx;
    logic       loop_en = 1'b0;
    logic       rx_bench = 1'b1;
    int         nvec = 0;
    int         nerr = 0;

    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_DLO = 3'd2, A_DMID = 3'd3,
                           A_LINE = 3'd4, A_CTRL = 3'd5, A_FLAG = 3'd6;

    always #10 clk = ~clk;
    assign rxd = loop_en ? txd : rx_bench;

    mmio_serial dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rxd),
        .txd       (txd),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    function automatic logic [7:0] bmask(input logic [7:0] d, input int n);
        logic [8:0] m;
        m = (9'd1 << n) - 9'd1;
        return d & m[7:0];
    endfunction

    function automatic logic bpar(input logic [7:0] d, input int n, input logic even);
        logic x;
        x = ^bmask(d, n);
        return even ? x : !x;
    endfunction

    function automatic logic [7:0] mkline(input int wl, input logic pe, input logic ev,
                                          input logic s2, input logic fe, input logic bk);
        logic [1:0] w;
        w = wl[1:0];
        return {1'b0, w, fe, s2, ev, pe, bk};
    endfunction

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic configure(input logic [11:0] dv, input logic [7:0] ln);
        wr(A_CTRL, 8'h00);
        wr(A_DLO, dv[7:0]);
        wr(A_DMID, {4'h0, dv[11:8]});
        wr(A_LINE, ln);
        wr(A_CTRL, 8'h01);
    endtask

    task automatic drive_rx(input logic [7:0] d, input int n, input logic pe, input logic ev,
                            input logic flip, input logic stop_low, input int p);
        @(negedge clk);
        rx_bench = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_bench = d[i];
            repeat (p) @(negedge clk);
        end
        if (pe) begin
            rx_bench = bpar(d, n, ev) ^ flip;
            repeat (p) @(negedge clk);
        end
        rx_bench = !stop_low;
        repeat (p) @(negedge clk);
        rx_bench = 1'b1;
        repeat (2*p) @(negedge clk);
    endtask

    task automatic measure(input logic lvl, output int n);
        n = 0;
        while (txd === lvl && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int         n;
        int         guard;
        void'($urandom(32'h5EED));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", txd, 1);
        rd(A_FLAG, v);
        chk("R1 flags after reset", v, 8'h10);
        chk("R13 irq_rx after reset", irq_rx, 0);
        chk("R13 irq_tx after reset", irq_tx, 1);

        // R7 / R11: fill the transmit queue while stopped
        wr(A_LINE, mkline(3, 0, 0, 0, 1, 0));
        for (int i = 0; i < 15; i++) wr(A_DATA, 8'h30 + 8'(i));
        rd(A_FLAG, v);
        chk("R7 not full at 15", v, 8'h10);
        wr(A_DATA, 8'h3F);
        rd(A_FLAG, v);
        chk("R7 full at 16", v, 8'h30);
        chk("R13 irq_tx when full", irq_tx, 0);
        wr(A_DATA, 8'hEE);
        repeat (50) @(negedge clk);
        chk("R11 no transmit while stopped", txd, 1);
        loop_en = 1'b1;
        wr(A_CTRL, 8'h01);
        repeat (3500) @(negedge clk);
        chk("R13 irq_rx with data", irq_rx, 1);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v);
            chk("R7 order through queues", v, 8'h30 + 8'(i));
        end
        rd(A_FLAG, v);
        chk("R7 write to full queue dropped", v, 8'h10);

        // R2 bit period, divisor 2
        loop_en = 1'b0;
        configure(12'd2, mkline(3, 0, 0, 0, 1, 0));
        wr(A_DATA, 8'h01);
        guard = 0;
        while (txd !== 1'b0 && guard < 1000) begin guard++; @(negedge clk); end
        measure(1'b0, n);
        chk("R2 start bit length div 2", n, 48);
        measure(1'b1, n);
        chk("R2 data bit length div 2", n, 48);
        rd(A_FLAG, v);
        chk("R12 busy during frame", v, 8'h18);
        repeat (600) @(negedge clk);
        rd(A_FLAG, v);
        chk("R12 idle after frame", v, 8'h10);

        // R2 upper divisor field, then R11 abort
        configure(12'h101, mkline(3, 0, 0, 0, 1, 0));
        wr(A_DATA, 8'hFF);
        guard = 0;
        while (txd !== 1'b0 && guard < 10000) begin guard++; @(negedge clk); end
        measure(1'b0, n);
        chk("R2 start bit length div 0x101", n, 4128);
        wr(A_CTRL, 8'h00);
        chk("R11 abort returns line high", txd, 1);
        rd(A_FLAG, v);
        chk("R11 abort clears busy", v, 8'h10);

        // R3 / R4 / R6 random formats in loopback
        for (int it = 0; it < 20; it++) begin
            int         wl, dv;
            logic       pe, ev, s2;
            logic [7:0] d;
            wl = int'($urandom % 4);
            dv = int'($urandom % 4);
            pe = 1'($urandom % 2);
            ev = 1'($urandom % 2);
            s2 = 1'($urandom % 2);
            d  = 8'($urandom);
            loop_en = 1'b1;
            configure(12'(dv), mkline(wl, pe, ev, s2, 1, 0));
            wr(A_DATA, d);
            repeat (16 * (dv + 1) * 14 + 40) @(negedge clk);
            rd(A_DATA, v);
            chk("R3 loopback data", v, bmask(d, wl + 5));
            rd(A_STAT, v);
            chk("R6 R4 clean status", v, 8'h00);
        end
        loop_en = 1'b0;

        // R4 parity errors, even then odd
        configure(12'd0, mkline(3, 1, 1, 0, 1, 0));
        drive_rx(8'hA5, 8, 1, 1, 1, 0, 16);
        rd(A_DATA, v);
        chk("R4 data with bad even parity", v, 8'hA5);
        rd(A_STAT, v);
        chk("R4 even parity error", v, 8'h02);
        configure(12'd0, mkline(2, 1, 0, 0, 1, 0));
        drive_rx(8'h5B, 7, 1, 0, 0, 0, 16);
        rd(A_DATA, v);
        chk("R3 seven-bit data", v, 8'h5B);
        rd(A_STAT, v);
        chk("R4 odd parity correct", v, 8'h00);
        drive_rx(8'h1C, 7, 1, 0, 1, 0, 16);
        rd(A_DATA, v);
        rd(A_STAT, v);
        chk("R4 odd parity error", v, 8'h02);

        // R5 framing, R6 status follows next character
        configure(12'd0, mkline(3, 0, 0, 0, 1, 0));
        drive_rx(8'h3C, 8, 0, 0, 0, 1, 16);
        drive_rx(8'hC3, 8, 0, 0, 0, 0, 16);
        rd(A_DATA, v);
        chk("R5 data with framing error", v, 8'h3C);
        rd(A_STAT, v);
        chk("R5 framing error", v, 8'h01);
        rd(A_DATA, v);
        chk("R6 next data", v, 8'hC3);
        rd(A_STAT, v);
        chk("R6 status follows popped char", v, 8'h00);

        // R8 overrun with the 16-entry queue
        for (int i = 0; i < 17; i++) drive_rx(8'h40 + 8'(i), 8, 0, 0, 0, 0, 16);
        chk("R13 irq_rx on full queue", irq_rx, 1);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v);
            chk("R8 stored data", v, 8'h40 + 8'(i));
            rd(A_STAT, v);
            chk("R8 overrun flag placement", v, (i == 15) ? 8'h04 : 8'h00);
        end
        rd(A_FLAG, v);
        chk("R8 extra char dropped", v, 8'h10);

        // R9 single-entry mode
        configure(12'd0, mkline(3, 0, 0, 0, 0, 0));
        wr(A_CTRL, 8'h00);
        wr(A_DATA, 8'h11);
        rd(A_FLAG, v);
        chk("R9 tx full after one", v, 8'h30);
        wr(A_CTRL, 8'h01);
        drive_rx(8'h21, 8, 0, 0, 0, 0, 16);
        drive_rx(8'h22, 8, 0, 0, 0, 0, 16);
        rd(A_DATA, v);
        chk("R9 single entry keeps first", v, 8'h21);
        rd(A_STAT, v);
        chk("R9 R8 overrun on single entry", v, 8'h04);
        rd(A_FLAG, v);
        chk("R9 rx empty after one pop", 32'(v[4]), 1);

        // R10 break
        wr(A_LINE, mkline(3, 0, 0, 0, 1, 1));
        @(negedge clk);
        chk("R10 break drives low", txd, 0);
        repeat (100) @(negedge clk);
        chk("R10 break holds low", txd, 0);
        wr(A_LINE, mkline(3, 0, 0, 0, 1, 0));
        @(negedge clk);
        chk("R10 release break", txd, 1);

        finish_up();
    end

endmodule